// File: doc/BRIEF.md
# Asynchronous SRAM Bridge

This block connects a single-request, clocked user port to an external asynchronous static RAM of 32768 words by 16 bits, organised as two byte lanes. A user presents a request with a direction flag, a word address, write data and a per-lane mask. The bridge then steps the memory's active-low chip select, write strobe, output strobe and lane selects through a fixed sequence, timed by a down-counter in clock cycles. It accepts a new request only while it is idle.

With a 10 ns clock, the counts are derived from minimum times in nanoseconds. A read holds the strobes for two cycles, then captures the bus and raises a valid strobe for one clock. A write first spends one quiet cycle with the bus released. It then drives data and holds the write strobe low for two cycles. After the write strobe rises it keeps driving the data for one more cycle before it returns to idle. The data pins are modelled as a separate input, output and output-enable, so that a pad ring can combine them.

Top module: `asram_bridge`

## Requirements
- R1: After reset, and whenever the bridge is idle, `ready_o` is 1, all memory strobes and both lane selects are high (inactive), `sram_dq_oe_o` is 0 and `rvalid_o` is 0.
- R2: A read request accepted at clock edge N drives chip select and output strobe low, with the write strobe high, for the two cycles after edges N and N+1. During those cycles the lane selects are low exactly where the mask bit is 1 (mask bit 0 = data bits 7:0, mask bit 1 = bits 15:8), and `sram_addr_o` carries the request's address.
- R3: A read samples the memory bus at edge N+2. After that edge `rdata_o` holds the sampled word with each unmasked lane forced to zero, and `rvalid_o` is high for exactly one clock. The bridge is idle again in that same cycle.
- R4: A write request accepted at edge N leaves every strobe high and the bus released for the cycle after edge N.
- R5: In the two cycles after edges N+1 and N+2, a write drives chip select and write strobe low and the output strobe high. The lane selects follow the mask as in R2, and `sram_dq_o` carries the write data with `sram_dq_oe_o` at 1.
- R6: In the cycle after edge N+3, the write raises all strobes and lane selects but keeps driving the write data. After edge N+4 the bridge is idle with the bus released.
- R7: A request presented while `ready_o` is 0 is ignored. It changes neither the address on the memory side nor the operation in progress, and no read results from it.
- R8: The output strobe is never low while the bridge drives the bus. The write strobe is never low while the output strobe is low.
- R9: A write changes only the lanes whose mask bit is 1. A write with mask 0 changes no data, as seen by reading the word back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, taken when `ready_o` is 1 |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 15 | Word address |
| wdata_i | input | 16 | Write data |
| mask_i | input | 2 | Lane mask, 1 = lane active; bit 0 = bits 7:0 |
| ready_o | output | 1 | Idle, able to accept a request |
| rdata_o | output | 16 | Read data, unmasked lanes zero |
| rvalid_o | output | 1 | One-clock strobe marking new `rdata_o` |
| sram_addr_o | output | 15 | Memory address |
| sram_ce_n_o | output | 1 | Memory chip select, active low |
| sram_we_n_o | output | 1 | Memory write strobe, active low |
| sram_oe_n_o | output | 1 | Memory output strobe, active low |
| sram_be_n_o | output | 2 | Lane selects, active low; bit 0 = bits 7:0 |
| sram_dq_o | output | 16 | Data driven toward the memory |
| sram_dq_oe_o | output | 1 | 1 = bridge drives the data pins |
| sram_dq_i | input | 16 | Data received from the memory pins |

## Verification
The bench builds the bridge with its default parameters: a 10 ns clock and 20 ns targets for the write pulse and the read wait, which give two-cycle strobes. At these values every phase of both sequences is short enough to compare on every clock against a behavioural phase counter. The bench also exercises both ends of the address range, each single lane, an empty mask and a request held high through a busy write.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_TURN,
    ST_WR,
    ST_HOLD
  } asram_state_e;

  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
    logic drive;
  } asram_strobe_t;

  // Strobe levels that belong to each phase of the sequence.
  function automatic asram_strobe_t strobes_for(asram_state_e s);
    asram_strobe_t r;
    r.ce_n  = 1'b1;
    r.we_n  = 1'b1;
    r.oe_n  = 1'b1;
    r.drive = 1'b0;
    case (s)
      ST_RD: begin
        r.ce_n = 1'b0;
        r.oe_n = 1'b0;
      end
      ST_WR: begin
        r.ce_n  = 1'b0;
        r.we_n  = 1'b0;
        r.drive = 1'b1;
      end
      ST_HOLD: r.drive = 1'b1;
      default: ;
    endcase
    return r;
  endfunction

  // Whole clock cycles covering a time in ns, never fewer than one.
  function automatic int unsigned cycles_for_ns(int unsigned ns, int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // A lane is selected on the memory side only in strobed phases.
  function automatic logic lanes_active(asram_state_e s);
    return (s == ST_RD) || (s == ST_WR);
  endfunction

endpackage

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int unsigned WE_CYC = 2,
  parameter int unsigned RD_CYC = 2,
  parameter int unsigned CNT_W  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic          wr_i,
  output asram_state_e  state_d_o,
  output asram_strobe_t strobe_o,
  output logic          ready_o,
  output logic          accept_o,
  output logic          rd_capture_o
);

  asram_state_e  state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  asram_strobe_t strobe_q;
  logic          last_w;

  assign last_w = (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = last_w ? cnt_q : cnt_q - 1'b1;
    case (state_q)
      ST_IDLE: begin
        if (req_i) begin
          state_d = wr_i ? ST_TURN : ST_RD;
          cnt_d   = wr_i ? '0 : CNT_W'(RD_CYC - 1);
        end
      end
      ST_RD:   if (last_w) state_d = ST_IDLE;
      ST_TURN: begin
        state_d = ST_WR;
        cnt_d   = CNT_W'(WE_CYC - 1);
      end
      ST_WR:   if (last_w) state_d = ST_HOLD;
      ST_HOLD: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      strobe_q <= strobes_for(ST_IDLE);
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      strobe_q <= strobes_for(state_d);
    end
  end

  assign state_d_o    = state_d;
  assign strobe_o     = strobe_q;
  assign ready_o      = (state_q == ST_IDLE);
  assign accept_o     = (state_q == ST_IDLE) && req_i;
  assign rd_capture_o = (state_q == ST_RD) && last_w;

endmodule

// File: rtl/asram_lanes.sv
module asram_lanes #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_i,
  input  logic [LANES-1:0]        mask_i,
  input  logic                    active_nx_i,
  input  logic                    capture_i,
  input  logic [LANES*LANE_W-1:0] dq_i,
  output logic [LANES-1:0]        be_n_o,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    rvalid_o
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic              mask_q;
    logic              mask_nx;
    logic              be_n_q;
    logic [LANE_W-1:0] rd_q;

    assign mask_nx = load_i ? mask_i[l] : mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q <= 1'b0;
        be_n_q <= 1'b1;
        rd_q   <= '0;
      end else begin
        mask_q <= mask_nx;
        be_n_q <= ~(active_nx_i & mask_nx);
        if (capture_i) rd_q <= mask_q ? dq_i[l*LANE_W +: LANE_W] : '0;
      end
    end

    assign be_n_o[l]                    = be_n_q;
    assign rdata_o[l*LANE_W +: LANE_W] = rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid_o <= 1'b0;
    else        rvalid_o <= capture_i;
  end

endmodule

// File: rtl/asram_wpath.sv
module asram_wpath #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (load_i) begin
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
    end
  end

endmodule

// File: rtl/asram_bridge.sv
module asram_bridge
  import asram_pkg::*;
#(
  parameter int unsigned ADDR_W  = 15,
  parameter int unsigned LANE_W  = 8,
  parameter int unsigned LANES   = 2,
  parameter int unsigned CLK_NS  = 10,
  parameter int unsigned T_WP_NS = 20,
  parameter int unsigned T_RD_NS = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_i,
  input  logic                    wr_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic [LANES-1:0]        mask_i,
  output logic                    ready_o,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    rvalid_o,
  output logic [ADDR_W-1:0]       sram_addr_o,
  output logic                    sram_ce_n_o,
  output logic                    sram_we_n_o,
  output logic                    sram_oe_n_o,
  output logic [LANES-1:0]        sram_be_n_o,
  output logic [LANES*LANE_W-1:0] sram_dq_o,
  output logic                    sram_dq_oe_o,
  input  logic [LANES*LANE_W-1:0] sram_dq_i
);

  localparam int unsigned DATA_W = LANES * LANE_W;
  localparam int unsigned WE_CYC = cycles_for_ns(T_WP_NS, CLK_NS);
  localparam int unsigned RD_CYC = cycles_for_ns(T_RD_NS, CLK_NS);
  localparam int unsigned CNT_W  = $clog2(max_u(WE_CYC, RD_CYC) + 1);

  asram_state_e  state_d_w;
  asram_strobe_t strobe_w;
  logic          accept_w;
  logic          rd_capture_w;
  logic          active_nx_w;

  asram_seq #(
    .WE_CYC(WE_CYC),
    .RD_CYC(RD_CYC),
    .CNT_W (CNT_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .wr_i        (wr_i),
    .state_d_o   (state_d_w),
    .strobe_o    (strobe_w),
    .ready_o     (ready_o),
    .accept_o    (accept_w),
    .rd_capture_o(rd_capture_w)
  );

  assign active_nx_w = lanes_active(state_d_w);

  asram_lanes #(
    .LANES (LANES),
    .LANE_W(LANE_W)
  ) u_lanes (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (accept_w),
    .mask_i     (mask_i),
    .active_nx_i(active_nx_w),
    .capture_i  (rd_capture_w),
    .dq_i       (sram_dq_i),
    .be_n_o     (sram_be_n_o),
    .rdata_o    (rdata_o),
    .rvalid_o   (rvalid_o)
  );

  asram_wpath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_wpath (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (accept_w),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .addr_o (sram_addr_o),
    .wdata_o(sram_dq_o)
  );

  assign sram_ce_n_o  = strobe_w.ce_n;
  assign sram_we_n_o  = strobe_w.we_n;
  assign sram_oe_n_o  = strobe_w.oe_n;
  assign sram_dq_oe_o = strobe_w.drive;

endmodule

// File: rtl/asram_bridge_chk.sv
module asram_bridge_chk #(
  parameter int unsigned LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ready_o,
  input logic             rvalid_o,
  input logic             sram_ce_n_o,
  input logic             sram_we_n_o,
  input logic             sram_oe_n_o,
  input logic [LANES-1:0] sram_be_n_o,
  input logic             sram_dq_oe_o,
  input logic             rd_capture_w
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> sram_ce_n_o && sram_we_n_o && sram_oe_n_o && !sram_dq_oe_o && (&sram_be_n_o)); // R1

  AST_READ_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n_o |-> !sram_ce_n_o && sram_we_n_o); // R2

  AST_CAPTURE_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rd_capture_w |=> rvalid_o && ready_o); // R3

  AST_VALID_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid_o |=> !rvalid_o); // R3

  AST_DRIVE_AFTER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_dq_oe_o) |-> $past(sram_oe_n_o) && $past(sram_ce_n_o)); // R4

  AST_WE_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_we_n_o) |=> !sram_we_n_o); // R5

  AST_WE_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n_o |-> !sram_ce_n_o && sram_dq_oe_o && !(&sram_be_n_o) || !sram_we_n_o && (&sram_be_n_o) && sram_dq_oe_o); // R5

  AST_DATA_HELD_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n_o) |-> sram_dq_oe_o && sram_ce_n_o); // R6

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(!sram_oe_n_o && sram_dq_oe_o)); // R8

  AST_NO_WE_DURING_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !(!sram_oe_n_o && !sram_we_n_o)); // R8

endmodule

bind asram_bridge asram_bridge_chk #(.LANES(LANES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ready_o     (ready_o),
  .rvalid_o    (rvalid_o),
  .sram_ce_n_o (sram_ce_n_o),
  .sram_we_n_o (sram_we_n_o),
  .sram_oe_n_o (sram_oe_n_o),
  .sram_be_n_o (sram_be_n_o),
  .sram_dq_oe_o(sram_dq_oe_o),
  .rd_capture_w(rd_capture_w)
);

// File: tb/asram_bridge_test.sv
module asram_bridge_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        wr = 1'b0;
  logic [14:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [1:0]  mask = '0;
  logic        ready;
  logic [15:0] rdata;
  logic        rvalid;
  logic [14:0] sram_addr;
  logic        ce_n, we_n, oe_n;
  logic [1:0]  be_n;
  logic [15:0] dq_o;
  logic        dq_oe;
  logic [15:0] dq_i;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  asram_bridge uut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .mask_i(mask), .ready_o(ready), .rdata_o(rdata),
    .rvalid_o(rvalid), .sram_addr_o(sram_addr), .sram_ce_n_o(ce_n),
    .sram_we_n_o(we_n), .sram_oe_n_o(oe_n), .sram_be_n_o(be_n),
    .sram_dq_o(dq_o), .sram_dq_oe_o(dq_oe), .sram_dq_i(dq_i)
  );

  // ---- memory model on the pins ----
  logic [15:0] mem [int];
  logic [15:0] mem_word = '0;

  function automatic logic [15:0] mem_get(logic [14:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 16'h0000;
  endfunction

  function automatic logic [15:0] keep_lanes(logic [15:0] v, logic [1:0] m);
    return {m[1] ? v[15:8] : 8'h00, m[0] ? v[7:0] : 8'h00};
  endfunction

  always @(negedge clk) mem_word = mem_get(sram_addr);

  always_comb begin
    dq_i[7:0]  = (!ce_n && !oe_n && we_n && !be_n[0]) ? mem_word[7:0]  : 8'hA5;
    dq_i[15:8] = (!ce_n && !oe_n && we_n && !be_n[1]) ? mem_word[15:8] : 8'hA5;
  end

  always @(posedge clk) begin
    if (rst_n && !ce_n && !we_n) begin
      logic [15:0] w;
      w = mem_get(sram_addr);
      if (!be_n[0]) w[7:0]  = dq_o[7:0];
      if (!be_n[1]) w[15:8] = dq_o[15:8];
      mem[int'(sram_addr)] = w;
    end
  end

  // ---- behavioural reference: phase counter ----
  int          ph = 0;
  bit          m_wr = 0;
  logic [14:0] m_addr = '0;
  logic [15:0] m_wdata = '0;
  logic [1:0]  m_mask = '0;
  logic        m_rvalid = 0;
  logic [15:0] m_rdata = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; m_wr = 0; m_addr = '0; m_wdata = '0; m_mask = '0;
      m_rvalid = 0; m_rdata = '0;
    end else begin
      m_rvalid = 0;
      if (ph == 0) begin
        if (req) begin
          m_wr = wr; m_addr = addr; m_wdata = wdata; m_mask = mask; ph = 1;
        end
      end else if (!m_wr && ph == 2) begin
        m_rdata  = keep_lanes(mem_get(m_addr), m_mask);
        m_rvalid = 1;
        ph = 0;
      end else if (m_wr && ph == 4) begin
        ph = 0;
      end else begin
        ph++;
      end
    end
  end

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      bit rd_act, wr_act, drv;
      logic [7:0] e_vec, a_vec;
      string tag;
      rd_act = !m_wr && (ph == 1 || ph == 2);
      wr_act = m_wr && (ph == 2 || ph == 3);
      drv    = m_wr && ph >= 2;
      e_vec = {ph == 0, !(rd_act || wr_act), !wr_act, !rd_act,
               (rd_act || wr_act) ? ~m_mask : 2'b11, drv, m_rvalid};
      a_vec = {ready, ce_n, we_n, oe_n, be_n, dq_oe, rvalid};
      if (ph == 0)      tag = m_rvalid ? "R3" : "R1";
      else if (!m_wr)   tag = "R2";
      else if (ph == 1) tag = "R4";
      else if (ph == 4) tag = "R6";
      else              tag = "R5";
      check(tag, 64'(a_vec), 64'(e_vec), "strobes {rdy,ce,we,oe,be,oe_dq,vld}");
      check(tag, {17'h0, sram_addr, rdata}, {17'h0, m_addr, m_rdata}, "{addr,rdata}");
      if (drv) check(tag, 64'(dq_o), 64'(m_wdata), "write data");
      check("R8", 64'(!oe_n && dq_oe), 64'(0), "contention");
    end
  end

  // ---- stimulus helpers ----
  task automatic issue(bit w, logic [14:0] a, logic [15:0] d, logic [1:0] m);
    @(negedge clk);
    while (!ready) @(negedge clk);
    req = 1'b1; wr = w; addr = a; wdata = d; mask = m;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic do_write(logic [14:0] a, logic [15:0] d, logic [1:0] m);
    issue(1'b1, a, d, m);
    while (!ready) @(negedge clk);
  endtask

  task automatic do_read(logic [14:0] a, logic [1:0] m, output logic [15:0] v);
    issue(1'b0, a, 16'h0, m);
    while (!rvalid) @(negedge clk);
    v = rdata;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    logic [15:0] v;
    repeat (3) @(negedge clk);
    // R1: reset state while reset is held
    check("R1", {58'h0, ready, ce_n, we_n, oe_n, dq_oe, rvalid},
          {58'h0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, "reset strobes");
    check("R1", 64'(be_n), 64'(2'b11), "reset lane selects");
    rst_n = 1'b1;

    // R9: full write then read back, both address extremes
    do_write(15'h0000, 16'h1234, 2'b11);
    do_write(15'h7FFF, 16'hBEEF, 2'b11);
    do_read(15'h0000, 2'b11, v);
    check("R9", 64'(v), 64'(16'h1234), "readback low address");
    do_read(15'h7FFF, 2'b11, v);
    check("R9", 64'(v), 64'(16'hBEEF), "readback top address");

    // R9: single-lane writes
    do_write(15'h0000, 16'hABCD, 2'b01);
    do_read(15'h0000, 2'b11, v);
    check("R9", 64'(v), 64'(16'h12CD), "low-lane write");
    do_write(15'h0000, 16'h5600, 2'b10);
    do_read(15'h0000, 2'b11, v);
    check("R9", 64'(v), 64'(16'h56CD), "high-lane write");

    // R3: single-lane reads zero the other lane
    do_read(15'h0000, 2'b01, v);
    check("R3", 64'(v), 64'(16'h00CD), "low-lane read");
    do_read(15'h0000, 2'b10, v);
    check("R3", 64'(v), 64'(16'h5600), "high-lane read");

    // R9: empty mask changes nothing
    do_write(15'h0000, 16'hFFFF, 2'b00);
    do_read(15'h0000, 2'b11, v);
    check("R9", 64'(v), 64'(16'h56CD), "mask 0 write");

    // R7: request held through a busy write is ignored
    @(negedge clk);
    req = 1'b1; wr = 1'b1; addr = 15'h0123; wdata = 16'h0F0F; mask = 2'b11;
    @(negedge clk);
    req = 1'b1; wr = 1'b0; addr = 15'h0456; mask = 2'b11;
    repeat (3) @(negedge clk);
    check("R7", 64'(sram_addr), 64'(15'h0123), "address during busy");
    req = 1'b0;
    repeat (4) @(negedge clk);
    check("R7", 64'(rvalid), 64'(0), "no read from ignored request");
    do_read(15'h0456, 2'b11, v);
    check("R7", 64'(v), 64'(16'h0000), "ignored address untouched");
    do_read(15'h0123, 2'b11, v);
    check("R7", 64'(v), 64'(16'h0F0F), "busy write completed");

    // back-to-back read then write then read
    do_read(15'h7FFF, 2'b11, v);
    do_write(15'h7FFF, 16'h0A0B, 2'b11);
    do_read(15'h7FFF, 2'b11, v);
    check("R9", 64'(v), 64'(16'h0A0B), "write after read");

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule